// File: doc/BRIEF.md
# AXI4 Burst Read Master

This block turns queued read commands into AXI4 read bursts and hands the returned data to a local consumer. A producer pushes a command made of a 32-bit start address and an 8-bit length field, where the field holds the beat count minus one. The command waits in a small queue until the block may issue it on the read address channel.

Each issued burst leaves its length in a tracking queue. Up to 16 bursts may be outstanding at once. Every beat that comes back on the read data channel is counted against the oldest tracked length, so that a misplaced RLAST is detected. The 64-bit beats go into a read-data queue. The consumer drains that queue using a read enable and two status flags, not-empty and not-almost-empty.

Only one transaction ID is used, so bursts return in the order they were issued.

Top module: `rd_burst_master`

## Requirements
- R1: `cmd_full` is high exactly when the command queue holds CMD_DEPTH (default 4) entries. A `cmd_push` while `cmd_full` is high is ignored and does not change the queue contents.
- R2: Commands are issued on the address channel in the order they were pushed, with `ar_addr`/`ar_len` taken from the command. The fixed fields are `ar_id`=0, `ar_lock`=2'b00, `ar_burst`=2'b01 (incrementing) and `ar_size`=3'b011 (8 bytes per beat).
- R3: Once `ar_valid` is high it stays high, with `ar_addr` and `ar_len` unchanged, until a cycle in which `ar_ready` is high.
- R4: `ar_valid` is high exactly when the command queue is non-empty and fewer than MAX_OUTST (default 16) bursts are outstanding. A burst counts as outstanding from its address handshake until its beat with `r_last` is accepted.
- R5: `r_ready` is high exactly when the read-data queue (RDQ_DEPTH entries, default 16) has a free entry, so no accepted beat is lost.
- R6: `rd_data` shows the oldest queued beat. Each `rd_pop` on a non-empty queue removes exactly one beat. A `rd_pop` on an empty queue is ignored.
- R7: `rd_not_empty` is high when at least one beat is queued. `rd_not_almost_empty` is high when at least AE_LEVEL (default 2) beats are queued.
- R8: A consumer that drives `rd_pop` from `rd_not_empty` receives every beat exactly once and in order, for bursts of 1, 8, 16 and 128 beats.
- R9: `proto_err` is set by any of the following, and stays set until reset:
  - an accepted beat carries `r_last` when its index within the burst differs from the tracked length field;
  - an accepted beat lacks `r_last` at that index;
  - a beat arrives while no burst is outstanding.
- R10: During reset, `ar_valid`, `cmd_full`, `rd_not_empty`, `rd_not_almost_empty` and `proto_err` are low, and `r_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_push | input | 1 | Push a read command |
| cmd_addr | input | 32 | Burst start address |
| cmd_len | input | 8 | Beats in burst minus one |
| cmd_full | output | 1 | Command queue full |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | output | 1 | Transaction ID, always 0 |
| ar_addr | output | 32 | Read address |
| ar_len | output | 8 | Burst length field |
| ar_size | output | 3 | Beat size code |
| ar_burst | output | 2 | Burst type |
| ar_lock | output | 2 | Lock type, always 0 |
| r_valid | input | 1 | Read data valid |
| r_ready | output | 1 | Read data ready |
| r_data | input | 64 | Read data beat |
| r_last | input | 1 | Last beat of burst |
| rd_pop | input | 1 | Consumer read enable |
| rd_data | output | 64 | Oldest queued beat |
| rd_not_empty | output | 1 | Read-data queue holds a beat |
| rd_not_almost_empty | output | 1 | Read-data queue holds at least AE_LEVEL beats |
| proto_err | output | 1 | Sticky protocol error |

## Verification
The assertions assume the following about the subordinate side:
- It never returns a beat before the matching address handshake.
- It holds `r_valid` and its beat steady while `r_ready` is low.

The bench's subordinate model obeys both rules. It queues each accepted address and replays the bursts strictly in issue order. After a stalled beat it keeps presenting the same beat until the beat is taken. The assertions place no limit on the producer or the consumer. The stimulus therefore deliberately pushes into a full command queue and pops an empty data queue. A single early RLAST is injected only after all well-formed traffic has drained.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;
  localparam logic [1:0] BURST_INCR = 2'b01;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
  } rd_cmd_t;

  // encoded beat size for a given number of bytes per beat
  function automatic logic [2:0] size_code(input int unsigned bytes_per_beat);
    return 3'($clog2(bytes_per_beat));
  endfunction

  // true when the RLAST flag disagrees with the position inside the burst
  function automatic logic last_mismatch(input logic [LEN_W-1:0] beat_idx,
                                         input logic [LEN_W-1:0] burst_len,
                                         input logic last);
    return last != (beat_idx == burst_len);
  endfunction
endpackage

// File: rtl/rbm_fifo.sv
module rbm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign do_wr = push && !full;
  assign do_rd = pop && !empty;
  assign head  = mem[rp];
  assign count = cnt;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rbm_beat_tracker.sv
module rbm_beat_tracker
  import rbm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_fire,
  input  logic             beat_last,
  input  logic             trk_valid,
  input  logic [LEN_W-1:0] trk_len,
  output logic             burst_done,
  output logic             err_hit,
  output logic             err_sticky
);
  logic [LEN_W-1:0] beat_cnt;

  assign burst_done = beat_fire && beat_last;
  assign err_hit    = beat_fire &&
                      (!trk_valid || last_mismatch(beat_cnt, trk_len, beat_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_cnt   <= '0;
      err_sticky <= 1'b0;
    end else begin
      if (burst_done)     beat_cnt <= '0;
      else if (beat_fire) beat_cnt <= beat_cnt + 1'b1;
      if (err_hit) err_sticky <= 1'b1;
    end
  end
endmodule

// File: rtl/rd_burst_master.sv
module rd_burst_master
  import rbm_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int CMD_DEPTH = 4,
  parameter int MAX_OUTST = 16,
  parameter int RDQ_DEPTH = 16,
  parameter int AE_LEVEL  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_push,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_full,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [0:0]        ar_id,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [LEN_W-1:0]  ar_len,
  output logic [2:0]        ar_size,
  output logic [1:0]        ar_burst,
  output logic [1:0]        ar_lock,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [DATA_W-1:0] r_data,
  input  logic              r_last,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_not_empty,
  output logic              rd_not_almost_empty,
  output logic              proto_err
);
  localparam int BEAT_BYTES = DATA_W / 8;
  localparam int CQ_CW = $clog2(CMD_DEPTH + 1);
  localparam int OT_CW = $clog2(MAX_OUTST + 1);
  localparam int RQ_CW = $clog2(RDQ_DEPTH + 1);

  // named internal events
  logic             ar_fire, r_fire, burst_done, err_hit;
  logic             cmd_empty, trk_full, trk_empty, rdq_full, rdq_empty;
  logic [CQ_CW-1:0] cmd_cnt;
  logic [OT_CW-1:0] outst_cnt;
  logic [RQ_CW-1:0] rdq_cnt;
  logic [LEN_W-1:0] trk_len;
  rd_cmd_t          cmd_in, cmd_head;

  assign cmd_in = '{addr: cmd_addr, len: cmd_len};

  rbm_fifo #(.W($bits(rd_cmd_t)), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .push(cmd_push), .pop(ar_fire),
    .din(cmd_in), .head(cmd_head), .full(cmd_full), .empty(cmd_empty),
    .count(cmd_cnt)
  );

  rbm_fifo #(.W(LEN_W), .DEPTH(MAX_OUTST)) u_trkq (
    .clk(clk), .rst_n(rst_n), .push(ar_fire), .pop(burst_done),
    .din(cmd_head.len), .head(trk_len), .full(trk_full), .empty(trk_empty),
    .count(outst_cnt)
  );

  rbm_fifo #(.W(DATA_W), .DEPTH(RDQ_DEPTH)) u_rdq (
    .clk(clk), .rst_n(rst_n), .push(r_fire), .pop(rd_pop),
    .din(r_data), .head(rd_data), .full(rdq_full), .empty(rdq_empty),
    .count(rdq_cnt)
  );

  rbm_beat_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .beat_fire(r_fire), .beat_last(r_last),
    .trk_valid(!trk_empty), .trk_len(trk_len), .burst_done(burst_done),
    .err_hit(err_hit), .err_sticky(proto_err)
  );

  // address channel
  assign ar_valid = !cmd_empty && !trk_full;
  assign ar_fire  = ar_valid && ar_ready;
  assign ar_addr  = cmd_head.addr;
  assign ar_len   = cmd_head.len;
  assign ar_id    = 1'b0;
  assign ar_lock  = 2'b00;
  assign ar_burst = BURST_INCR;
  assign ar_size  = size_code(BEAT_BYTES);

  // data channel
  assign r_ready = !rdq_full;
  assign r_fire  = r_valid && r_ready;

  assign rd_not_empty = !rdq_empty;
  generate
    if (AE_LEVEL <= 1) begin : g_ae_simple
      assign rd_not_almost_empty = !rdq_empty;
    end else begin : g_ae_level
      assign rd_not_almost_empty = (rdq_cnt >= RQ_CW'(AE_LEVEL));
    end
  endgenerate
endmodule

// File: rtl/rbm_checker.sv
module rbm_checker #(
  parameter int MAX_OUTST = 16,
  parameter int RDQ_DEPTH = 16,
  localparam int OT_CW = $clog2(MAX_OUTST + 1),
  localparam int RQ_CW = $clog2(RDQ_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ar_valid,
  input logic             ar_ready,
  input logic [31:0]      ar_addr,
  input logic [7:0]       ar_len,
  input logic             ar_fire,
  input logic             r_fire,
  input logic             r_last,
  input logic             r_ready,
  input logic             rd_pop,
  input logic             rd_not_empty,
  input logic [OT_CW-1:0] outst_cnt,
  input logic [RQ_CW-1:0] rdq_cnt,
  input logic             proto_err
);
  p_ar_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr) && $stable(ar_len)));

  p_no_ar_at_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (outst_cnt == OT_CW'(MAX_OUTST)) |-> !ar_valid);

  p_outst_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    outst_cnt <= OT_CW'(MAX_OUTST));

  p_outst_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_fire && !(r_fire && r_last)) |=> (outst_cnt == $past(outst_cnt) + 1'b1));

  p_outst_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (r_fire && r_last && !ar_fire && outst_cnt != '0) |=>
      (outst_cnt == $past(outst_cnt) - 1'b1));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdq_cnt == RQ_CW'(RDQ_DEPTH)) |-> !r_ready);

  p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    r_fire |=> rd_not_empty);

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && !r_fire && rdq_cnt == RQ_CW'(1)) |=> !rd_not_empty);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

bind rd_burst_master rbm_checker #(
  .MAX_OUTST(MAX_OUTST), .RDQ_DEPTH(RDQ_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ar_valid(ar_valid), .ar_ready(ar_ready),
  .ar_addr(ar_addr), .ar_len(ar_len), .ar_fire(ar_fire), .r_fire(r_fire),
  .r_last(r_last), .r_ready(r_ready), .rd_pop(rd_pop),
  .rd_not_empty(rd_not_empty), .outst_cnt(outst_cnt), .rdq_cnt(rdq_cnt),
  .proto_err(proto_err)
);

// File: tb/tb_rd_burst_master.sv
`timescale 1ns/1ps
module tb_rd_burst_master;
  localparam int CMD_DEPTH = 4;
  localparam int MAXO      = 16;
  localparam int RDQ       = 16;
  localparam int NCMD      = 18;
  localparam int LENS [NCMD] = '{0, 7, 15, 127, 0, 1, 2, 3, 0, 1, 2, 3, 0, 1, 2, 3, 0, 5};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_push = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [7:0]  cmd_len = '0;
  logic        cmd_full, ar_valid, ar_ready = 1'b0;
  logic [0:0]  ar_id;
  logic [31:0] ar_addr;
  logic [7:0]  ar_len;
  logic [2:0]  ar_size;
  logic [1:0]  ar_burst, ar_lock;
  logic        r_valid = 1'b0, r_ready, r_last = 1'b0;
  logic [63:0] r_data = '0, rd_data;
  logic        rd_pop = 1'b0, rd_not_empty, rd_not_almost_empty, proto_err;

  always #2 clk = ~clk;

  rd_burst_master dut (
    .clk(clk), .rst_n(rst_n), .cmd_push(cmd_push), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_full(cmd_full), .ar_valid(ar_valid),
    .ar_ready(ar_ready), .ar_id(ar_id), .ar_addr(ar_addr), .ar_len(ar_len),
    .ar_size(ar_size), .ar_burst(ar_burst), .ar_lock(ar_lock),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_last(r_last),
    .rd_pop(rd_pop), .rd_data(rd_data), .rd_not_empty(rd_not_empty),
    .rd_not_almost_empty(rd_not_almost_empty), .proto_err(proto_err)
  );

  int errors = 0, checks = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model state
  logic [31:0] mc_addr[$];
  int          mc_len[$];
  int          m_out[$];
  logic [63:0] dq[$];
  int          m_beat = 0;
  bit          m_err = 0;
  // subordinate model
  logic [31:0] sa[$];
  int          sl[$];
  bit          se[$];
  int          sb = 0;
  bit          s_pend = 0;

  initial begin
    int  idx = 0, cyc = 0, sent = 0, popped = 0;
    bit  hold_r = 1, saw16 = 0, saw_full = 0, err_mode = 0, err_pushed = 0;
    bit  prev_stall = 0;
    logic [39:0] prev_ar = '0;
    repeat (3) @(negedge clk);
    // R10 reset values
    chk("R10 ar_valid", ar_valid, 0);
    chk("R10 cmd_full", cmd_full, 0);
    chk("R10 rd_not_empty", rd_not_empty, 0);
    chk("R10 rd_not_almost_empty", rd_not_almost_empty, 0);
    chk("R10 proto_err", proto_err, 0);
    chk("R10 r_ready", r_ready, 1);
    rst_n = 1'b1;
    while (!finished) begin
      bit push_ok, arf, rf, popf;
      cyc++;
      // compare outputs with the model
      chk("R1 cmd_full", cmd_full, mc_addr.size() == CMD_DEPTH);
      chk("R4 ar_valid", ar_valid, mc_addr.size() > 0 && m_out.size() < MAXO);
      if (mc_addr.size() > 0 && m_out.size() < MAXO) begin
        chk("R2 ar_addr", ar_addr, mc_addr[0]);
        chk("R2 ar_len", ar_len, 8'(mc_len[0]));
        chk("R2 fixed fields", {ar_id, ar_lock, ar_burst, ar_size}, {1'b0, 2'b00, 2'b01, 3'b011});
      end
      if (prev_stall) begin
        chk("R3 ar_valid held", ar_valid, 1);
        chk("R3 ar fields stable", {ar_addr, ar_len}, prev_ar);
      end
      chk("R5 r_ready", r_ready, dq.size() < RDQ);
      chk("R7 rd_not_empty", rd_not_empty, dq.size() > 0);
      chk("R7 rd_not_almost_empty", rd_not_almost_empty, dq.size() >= 2);
      if (dq.size() > 0) chk("R6 rd_data", rd_data, dq[0]);
      chk("R9 proto_err", proto_err, m_err);
      if (!r_ready) saw_full = 1;

      // drive: consumer (pops on empty early on, then tied to not-empty)
      rd_pop = (cyc < 4) ? 1'b1 : (saw_full ? rd_not_empty : 1'b0);
      // drive: producer (keeps pushing even while full)
      if (idx < NCMD) begin
        cmd_push = 1'b1;
        cmd_addr = 32'h1000_0000 + 32'(idx) * 32'h1000;
        cmd_len  = 8'(LENS[idx]);
      end else if (!err_pushed && mc_addr.size() == 0 && m_out.size() == 0 &&
                   sa.size() == 0 && dq.size() == 0) begin
        err_mode = 1;
        cmd_push = 1'b1;
        cmd_addr = 32'h2000_0000;
        cmd_len  = 8'd3;
      end else begin
        cmd_push = 1'b0;
      end
      ar_ready = ($urandom % 4) != 0;
      // drive: subordinate, beats replayed in issue order
      if (!s_pend) begin
        r_valid = !hold_r && sa.size() > 0 && (($urandom % 4) != 0);
        if (r_valid) begin
          r_data = {sa[0], 32'(sb)};
          r_last = (sb == (se[0] ? sl[0] - 1 : sl[0]));
        end else begin
          r_last = 1'b0;
        end
      end

      // model of the next clock edge
      push_ok = cmd_push && mc_addr.size() < CMD_DEPTH;
      arf     = mc_addr.size() > 0 && m_out.size() < MAXO && ar_ready;
      rf      = r_valid && dq.size() < RDQ;
      popf    = rd_pop && dq.size() > 0;
      prev_stall = (mc_addr.size() > 0 && m_out.size() < MAXO) && !ar_ready;
      prev_ar    = {ar_addr, ar_len};
      s_pend  = r_valid && !rf;
      if (rf) begin
        if (m_out.size() == 0) m_err = 1;
        else if (r_last != (m_beat == m_out[0])) m_err = 1;
        if (r_last) begin
          m_beat = 0;
          if (m_out.size() > 0) void'(m_out.pop_front());
          void'(sa.pop_front()); void'(sl.pop_front()); void'(se.pop_front());
          sb = 0;
        end else begin
          m_beat++;
          sb++;
        end
      end
      if (popf) begin void'(dq.pop_front()); popped++; end
      if (rf) begin dq.push_back(r_data); sent++; end
      if (arf) begin
        m_out.push_back(mc_len[0]);
        sa.push_back(mc_addr[0]); sl.push_back(mc_len[0]); se.push_back(err_mode);
        void'(mc_addr.pop_front()); void'(mc_len.pop_front());
      end
      if (push_ok) begin
        mc_addr.push_back(cmd_addr);
        mc_len.push_back(int'(cmd_len));
        if (idx < NCMD) idx++;
        else err_pushed = 1;
      end
      if (m_out.size() == MAXO) begin saw16 = 1; hold_r = 0; end
      if (cyc > 3000) hold_r = 0;
      if (err_pushed && mc_addr.size() == 0 && m_out.size() == 0 &&
          sa.size() == 0 && dq.size() == 0 && !s_pend) finished = 1;
      @(negedge clk);
    end
    cmd_push = 1'b0; r_valid = 1'b0; rd_pop = 1'b0;
    repeat (3) @(negedge clk);
    chk("R4 reached 16 outstanding", saw16, 1);
    chk("R5 queue filled and stalled r_ready", saw_full, 1);
    chk("R8 beats delivered once", popped, sent);
    chk("R8 total beats", sent, 1 + 8 + 16 + 128 + 3 * 10 + 1 + 6 + 3);
    chk("R9 sticky after early last", proto_err, 1);
    chk("R6 queue empty at end", rd_not_empty, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule